// File: doc/BRIEF.md
# Segmented Address Relocation Unit

This block maps a 16-bit virtual address onto a 22-bit physical address for a processor that runs in kernel, supervisor or user mode. The virtual space of each mode is cut into eight segments, each with its own base word and descriptor word. A segment can sit anywhere in physical memory. Its length is set in 64-byte blocks, and it can grow either upward from its base or downward, as a stack does. Every mode has an instruction bank and a data bank of eight segments each. A per-mode split switch decides whether data references actually use the data bank.

Each access is checked against the descriptor of its segment. The block raises `acc_abort` when the access must not complete, and `acc_trap` when it may complete but software wants to be told. The first abort is recorded in a status word: its kind, the mode, the bank, the segment number, and the virtual address in a separate fault register. That record then stays frozen until software clears it. Software programs every register through a small address/data port with a combinational read path.

Top module: `seg_reloc_unit`

## Requirements
- R1: While status bit 0 (relocation enable) is clear, `phys_addr` is `acc_va` zero-extended. Neither flag is raised, and no status, fault or descriptor state changes.
- R2: While relocation is on, `acc_va[15:13]` selects the segment and `phys_addr` = base × 64 + `acc_va[12:0]`, where base is the 16-bit base word of the selected entry.
- R3: The block number is `acc_va[12:6]` and the limit is descriptor bits 14:8. With descriptor bit 3 clear (upward), an access aborts when block > limit. With bit 3 set (downward), it aborts when block < limit. Either case sets status bit 14.
- R4: Descriptor bits 2:0 hold the access code. Codes 0, 3 and 7 abort every access and set status bit 15; mode code 2'b10 aborts the same way. Code 1 aborts writes and traps reads. Code 2 aborts writes. Any abort on a write to code 1 or 2 sets status bit 13. Code 4 traps every access, code 5 traps writes, and code 6 performs no check.
- R5: `acc_trap` is raised only for a trapping access that does not abort, and only while status bit 9 is set. Status bit 12 is set by any such access whatever bit 9 holds.
- R6: Mode codes are 00 kernel, 01 supervisor and 11 user. Split register bits 2, 1 and 0 enable the split for kernel, supervisor and user. A data reference (`acc_ifetch` low) uses the data bank only when its mode's split bit is set. Every other reference uses the instruction bank.
- R7: A vector fetch (`acc_vector` high) always uses the kernel data bank, whatever the mode input and the split bits hold.
- R8: A write that does not abort sets descriptor bit 6. A trapping access that does not abort sets descriptor bit 7. A port write to a descriptor stores bits 14:8, 3 and 2:0 and clears bits 7 and 6.
- R9: An abort that arrives while no abort bit is set captures the effective mode in status bits 6:5, the data-bank flag in bit 4 and the segment in bits 3:1, and loads the fault register with `acc_va`.
- R10: While any of status bits 15:13 is set, status bits 7:1 and the fault register hold their values. Later aborts still OR in their own kind bits.
- R11: Port map. When `cfg_addr[7]` is 0, `cfg_addr[6]` picks descriptor (1) or base (0), `[5:4]` the mode code, `[3]` the data bank and `[2:0]` the segment. Address 0x80 is the status word (writable bits 0xF27F), 0x81 is the fault register (read only) and 0x82 is the split register (bits 2:0). Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register port write strobe |
| cfg_addr | input | 8 | Register port address |
| cfg_wdata | input | 16 | Register port write data |
| cfg_rdata | output | 16 | Register port read data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_va | input | 16 | Virtual address |
| acc_write | input | 1 | Access is a write |
| acc_mode | input | 2 | Processor mode of the access |
| acc_ifetch | input | 1 | Instruction-stream reference (opcode, immediate, absolute) |
| acc_vector | input | 1 | Trap or interrupt vector fetch |
| phys_addr | output | 22 | Translated physical address |
| acc_abort | output | 1 | Access must not complete |
| acc_trap | output | 1 | Access completes but raises a trap |

## Verification
The bench probes both edges of both growth directions. An off-by-one limit compare would let block 11 through a 10-block upward segment, or reject block 100 of a downward segment whose limit is 100. Each access code is tried with a read and a write, which exposes a swapped read/write rule or a trap raised next to an abort. Bank selection is checked with the split on and off, and through a vector fetch issued in user mode; a design that ignored the split or the vector override would translate through the instruction bank and miss the expected base. The status sequence first causes an abort, then follows it with a second abort of another kind. A design that did not freeze would overwrite the segment, mode and fault address; one that did not accumulate would lose the length bit.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;
  localparam int VA_W    = 16;
  localparam int SEG_W   = 3;
  localparam int OFF_W   = 6;
  localparam int BLK_W   = VA_W - SEG_W - OFF_W;
  localparam int BASE_W  = 16;
  localparam int PA_W    = BASE_W + OFF_W;
  localparam int WORD_W  = 16;
  localparam int SEGS    = 1 << SEG_W;
  localparam int MODES   = 3;
  localparam int SLOT_W  = 2;
  localparam int ENTRIES = MODES * 2 * SEGS;
  localparam int IDX_W   = SLOT_W + 1 + SEG_W;

  // descriptor fields
  localparam int DSC_LIM_LSB = 8;
  localparam int DSC_TRAPPED = 7;
  localparam int DSC_WRITTEN = 6;
  localparam int DSC_DOWN    = 3;
  localparam logic [WORD_W-1:0] DSC_WMASK = 16'h7F0F;

  // status fields
  localparam int ST_NR       = 15;
  localparam int ST_LEN      = 14;
  localparam int ST_RO       = 13;
  localparam int ST_TRP      = 12;
  localparam int ST_TEN      = 9;
  localparam int ST_MODE_LSB = 5;
  localparam int ST_DSP      = 4;
  localparam int ST_SEG_LSB  = 1;
  localparam int ST_EN       = 0;
  localparam logic [WORD_W-1:0] ST_WMASK = 16'hF27F;

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00, MODE_SUPV = 2'b01, MODE_BAD = 2'b10, MODE_USER = 2'b11
  } cpu_mode_e;

  typedef struct packed {
    logic nonres;
    logic rdonly;
    logic trap;
  } verdict_t;

  function automatic logic [PA_W-1:0] phys_of(logic [BASE_W-1:0] base,
                                              logic [VA_W-1:0] va);
    return {base, {OFF_W{1'b0}}} + PA_W'(va[VA_W-SEG_W-1:0]);
  endfunction

  function automatic logic len_bad(logic down, logic [BLK_W-1:0] lim,
                                   logic [BLK_W-1:0] blk);
    return down ? (blk < lim) : (blk > lim);
  endfunction

  function automatic verdict_t judge(logic [2:0] code, logic wr);
    verdict_t v;
    v = '0;
    case (code)
      3'd1:    begin v.rdonly = wr; v.trap = ~wr; end
      3'd2:    v.rdonly = wr;
      3'd4:    v.trap = 1'b1;
      3'd5:    v.trap = wr;
      3'd6:    v = '0;
      default: v.nonres = 1'b1;
    endcase
    return v;
  endfunction

  function automatic logic [SLOT_W-1:0] mode_slot(logic [1:0] m);
    case (m)
      MODE_KERN: return 2'd0;
      MODE_SUPV: return 2'd1;
      MODE_USER: return 2'd2;
      default:   return 2'd3;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] entry_of(logic [SLOT_W-1:0] slot, logic dsp,
                                                logic [SEG_W-1:0] seg);
    return {slot, dsp, seg};
  endfunction
endpackage

// File: rtl/seg_regbank.sv
module seg_regbank
  import seg_reloc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_desc,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [BASE_W-1:0] lk_base,
  output logic [WORD_W-1:0] lk_desc,
  input  logic              mark_wr,
  input  logic              mark_tr,
  input  logic [IDX_W-1:0]  mark_idx
);
  logic [BASE_W-1:0] base_q [ENTRIES];
  logic [WORD_W-1:0] desc_q [ENTRIES];
  logic [IDX_W-1:0]  chk_idx_q;
  logic              cfg_hits_mark;

  assign cfg_hits_mark = cfg_we && cfg_desc && (cfg_idx == mark_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        base_q[i] <= '0;
        desc_q[i] <= '0;
      end
      chk_idx_q <= '0;
    end else begin
      chk_idx_q <= mark_idx;
      for (int i = 0; i < ENTRIES; i++) begin
        if (cfg_we && cfg_idx == IDX_W'(i)) begin
          if (cfg_desc) desc_q[i] <= cfg_wdata & DSC_WMASK;
          else          base_q[i] <= BASE_W'(cfg_wdata);
        end else if (mark_idx == IDX_W'(i)) begin
          desc_q[i][DSC_WRITTEN] <= desc_q[i][DSC_WRITTEN] | mark_wr;
          desc_q[i][DSC_TRAPPED] <= desc_q[i][DSC_TRAPPED] | mark_tr;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(cfg_idx) < ENTRIES)
      rd_data = cfg_desc ? desc_q[cfg_idx] : WORD_W'(base_q[cfg_idx]);
  end

  assign lk_base = (int'(lk_idx) < ENTRIES) ? base_q[lk_idx] : '0;
  assign lk_desc = (int'(lk_idx) < ENTRIES) ? desc_q[lk_idx] : '0;

  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mark_wr && !cfg_hits_mark |=> desc_q[chk_idx_q][DSC_WRITTEN]); // R8
  AST_TRAPPED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mark_tr && !cfg_hits_mark |=> desc_q[chk_idx_q][DSC_TRAPPED]); // R8
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_reloc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             slot_ok,
  input  logic [BLK_W-1:0] lim,
  input  logic             down,
  input  logic [2:0]       code,
  input  logic [BLK_W-1:0] blk,
  input  logic             is_write,
  output logic             nonres,
  output logic             len_flt,
  output logic             ro_flt,
  output logic             trap_hit,
  output logic             abort
);
  verdict_t v;

  always_comb begin
    v        = judge(code, is_write);
    nonres   = ~slot_ok | v.nonres;
    len_flt  = slot_ok & len_bad(down, lim, blk);
    ro_flt   = slot_ok & v.rdonly;
    abort    = nonres | len_flt | ro_flt;
    trap_hit = ~abort & v.trap;
  end

  AST_LEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && !abort |-> (down ? (blk >= lim) : (blk <= lim))); // R3
  AST_OPEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && slot_ok && code == 3'd6 && !len_flt |-> !abort && !trap_hit); // R4
  AST_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && is_write && (code == 3'd1 || code == 3'd2) |-> abort); // R4
endmodule

// File: rtl/seg_status_reg.sv
module seg_status_reg
  import seg_reloc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_stat,
  input  logic              we_split,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ev,
  input  logic              ev_nonres,
  input  logic              ev_len,
  input  logic              ev_ro,
  input  logic              ev_trap,
  input  logic [1:0]        ev_mode,
  input  logic              ev_dsp,
  input  logic [SEG_W-1:0]  ev_seg,
  input  logic [VA_W-1:0]   ev_va,
  output logic [WORD_W-1:0] stat_q,
  output logic [VA_W-1:0]   fault_q,
  output logic [2:0]        split_q
);
  logic frozen, ev_abort;

  assign frozen   = |stat_q[ST_NR:ST_RO];
  assign ev_abort = ev && (ev_nonres || ev_len || ev_ro);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      fault_q <= '0;
      split_q <= '0;
    end else begin
      if (we_split) split_q <= wdata[2:0];
      if (we_stat) begin
        stat_q <= wdata & ST_WMASK;
      end else if (ev) begin
        stat_q[ST_NR]  <= stat_q[ST_NR]  | ev_nonres;
        stat_q[ST_LEN] <= stat_q[ST_LEN] | ev_len;
        stat_q[ST_RO]  <= stat_q[ST_RO]  | ev_ro;
        stat_q[ST_TRP] <= stat_q[ST_TRP] | ev_trap;
        if (ev_abort && !frozen) begin
          stat_q[ST_MODE_LSB+1:ST_MODE_LSB] <= ev_mode;
          stat_q[ST_DSP]                    <= ev_dsp;
          stat_q[ST_SEG_LSB+SEG_W-1:ST_SEG_LSB] <= ev_seg;
          fault_q <= ev_va;
        end
      end
    end
  end

  AST_HOLD_WHEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !we_stat |=> $stable(stat_q[7:1]) && $stable(fault_q)); // R10
  AST_CAPTURE_VA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort && !frozen && !we_stat |=> fault_q == $past(ev_va)); // R9
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
  import seg_reloc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic [VA_W-1:0]   acc_va,
  input  logic              acc_write,
  input  logic [1:0]        acc_mode,
  input  logic              acc_ifetch,
  input  logic              acc_vector,
  output logic [PA_W-1:0]   phys_addr,
  output logic              acc_abort,
  output logic              acc_trap
);
  logic [WORD_W-1:0] stat_q, bank_rd, lk_desc;
  logic [VA_W-1:0]   fault_q;
  logic [2:0]        split_q;
  logic [BASE_W-1:0] lk_base;
  logic              reloc_on, active, ctl_sel, bank_we, cfg_slot_ok;
  logic [1:0]        eff_mode;
  logic [SLOT_W-1:0] slot, cfg_slot;
  logic              slot_ok, split_bit, use_d;
  logic [SEG_W-1:0]  seg;
  logic [IDX_W-1:0]  lk_idx, cfg_idx;
  logic              nonres, len_flt, ro_flt, trap_hit, chk_abort;
  logic              mark_en;
  logic              unused_desc_bits;

  assign reloc_on = stat_q[ST_EN];
  assign active   = acc_valid & reloc_on;
  assign eff_mode = acc_vector ? MODE_KERN : acc_mode;
  assign slot     = mode_slot(eff_mode);
  assign slot_ok  = (slot != 2'd3);
  assign seg      = acc_va[VA_W-1:VA_W-SEG_W];

  always_comb begin
    case (eff_mode)
      MODE_KERN: split_bit = split_q[2];
      MODE_SUPV: split_bit = split_q[1];
      MODE_USER: split_bit = split_q[0];
      default:   split_bit = 1'b0;
    endcase
  end

  assign use_d  = acc_vector | (split_bit & ~acc_ifetch);
  assign lk_idx = slot_ok ? entry_of(slot, use_d, seg) : '0;

  // register port decode
  assign ctl_sel     = cfg_addr[7];
  assign cfg_slot    = mode_slot(cfg_addr[5:4]);
  assign cfg_slot_ok = (cfg_slot != 2'd3);
  assign cfg_idx     = cfg_slot_ok ? entry_of(cfg_slot, cfg_addr[3], cfg_addr[2:0]) : '0;
  assign bank_we     = cfg_we & ~ctl_sel & cfg_slot_ok;

  always_comb begin
    cfg_rdata = '0;
    if (ctl_sel) begin
      case (cfg_addr[1:0])
        2'd0:    cfg_rdata = stat_q;
        2'd1:    cfg_rdata = WORD_W'(fault_q);
        2'd2:    cfg_rdata = WORD_W'(split_q);
        default: cfg_rdata = '0;
      endcase
    end else if (cfg_slot_ok) begin
      cfg_rdata = bank_rd;
    end
  end

  seg_regbank u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(bank_we), .cfg_desc(cfg_addr[6]), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rd_data(bank_rd),
    .lk_idx(lk_idx), .lk_base(lk_base), .lk_desc(lk_desc),
    .mark_wr(mark_en & acc_write), .mark_tr(mark_en & trap_hit), .mark_idx(lk_idx)
  );

  seg_access_check u_chk (
    .clk(clk), .rst_n(rst_n), .chk_en(active), .slot_ok(slot_ok),
    .lim(lk_desc[DSC_LIM_LSB+BLK_W-1:DSC_LIM_LSB]), .down(lk_desc[DSC_DOWN]),
    .code(lk_desc[2:0]), .blk(acc_va[OFF_W+BLK_W-1:OFF_W]), .is_write(acc_write),
    .nonres(nonres), .len_flt(len_flt), .ro_flt(ro_flt), .trap_hit(trap_hit),
    .abort(chk_abort)
  );

  assign unused_desc_bits = ^{lk_desc[WORD_W-1], lk_desc[7:4]};
  assign mark_en = active & ~chk_abort;

  seg_status_reg u_stat (
    .clk(clk), .rst_n(rst_n),
    .we_stat(cfg_we & ctl_sel & (cfg_addr[1:0] == 2'd0)),
    .we_split(cfg_we & ctl_sel & (cfg_addr[1:0] == 2'd2)),
    .wdata(cfg_wdata),
    .ev(active), .ev_nonres(nonres), .ev_len(len_flt), .ev_ro(ro_flt),
    .ev_trap(trap_hit), .ev_mode(eff_mode), .ev_dsp(use_d), .ev_seg(seg), .ev_va(acc_va),
    .stat_q(stat_q), .fault_q(fault_q), .split_q(split_q)
  );

  assign phys_addr = active ? phys_of(lk_base, acc_va) : PA_W'(acc_va);
  assign acc_abort = active & chk_abort;
  assign acc_trap  = active & trap_hit & stat_q[ST_TEN];

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !reloc_on |-> phys_addr == PA_W'(acc_va) && !acc_abort && !acc_trap); // R1
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_abort && acc_trap)); // R5
  AST_TRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_trap |-> stat_q[ST_TEN]); // R5
  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_abort && !acc_trap); // R2
endmodule

// File: tb/seg_reloc_unit_test.sv
`timescale 1ns/100ps
module seg_reloc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_va = '0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_mode = '0;
  logic        acc_ifetch = 1'b1;
  logic        acc_vector = 1'b0;
  logic [21:0] phys_addr;
  logic        acc_abort, acc_trap;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [21:0] g_pa;
  logic g_ab, g_tr;
  logic [15:0] rv;
  logic [2:0] split_m = 3'b000;

  always #2.5 clk = ~clk;

  seg_reloc_unit uut (.*);

  // row: va, mode, ifetch, vector, write, expected abort, expected trap
  localparam int ROWS = 22;
  localparam logic [22:0] TBL [ROWS] = '{
    {16'h0123, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h2000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'h4040, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h4040, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'h6000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'h6000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'h8000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'h8000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'hA000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'hA000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'hC280, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'hC2C0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'hF900, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'hF8C0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h2000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h2010, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h4000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h6000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h0004, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h1FFF, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h0000, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  function automatic string row_tag(int r);
    if (r >= 10 && r <= 13) return "R3";
    if (r == 14 || r == 16 || r == 17 || r == 18) return "R6";
    if (r == 19) return "R7";
    if (r == 20) return "R2";
    return "R4";
  endfunction

  function automatic int slot_of(logic [1:0] m);
    return (m == 2'd3) ? 2 : int'(m);
  endfunction

  // bench-side rule for the programmed base of each entry
  function automatic logic [15:0] base_for(int sl, int dsp, int sg);
    return 16'((sl * 16 + dsp * 8 + sg) * 256 + 3);
  endfunction

  function automatic logic [21:0] expect_pa(logic [15:0] va, logic [1:0] m, logic ifb, logic vec);
    int sl, dsp;
    logic sb;
    sb = (m == 2'd0) ? split_m[2] : (m == 2'd1) ? split_m[1] : split_m[0];
    sl  = vec ? 0 : slot_of(m);
    dsp = (vec || (sb && !ifb)) ? 1 : 0;
    return 22'(base_for(sl, dsp, int'(va[15:13]))) * 22'd64 + 22'(va[12:0]);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    cfg_addr = a; #1 d = cfg_rdata;
    @(negedge clk);
  endtask

  task automatic access(logic [15:0] va, logic [1:0] m, logic ifb, logic vec, logic w);
    acc_valid = 1'b1; acc_va = va; acc_mode = m; acc_ifetch = ifb;
    acc_vector = vec; acc_write = w;
    #1 g_pa = phys_addr; g_ab = acc_abort; g_tr = acc_trap;
    @(posedge clk); #1 acc_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] bank(logic dsc, logic [1:0] m, logic d, logic [2:0] g);
    return {1'b0, dsc, m, d, g};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state and pass-through
    rd(8'h80, rv); check("R1", rv, 16'h0000, "status after reset");
    access(16'hBEEF, 2'd3, 1'b0, 1'b0, 1'b1);
    check("R1", g_pa, 22'h00BEEF, "pass-through address");
    check("R1", {g_ab, g_tr}, 2'b00, "no flags while off");

    // program every entry
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      for (int d = 0; d < 2; d++)
        for (int g = 0; g < 8; g++) begin
          wr(bank(1'b0, 2'(m), 1'(d), 3'(g)), base_for(slot_of(2'(m)), d, g));
          wr(bank(1'b1, 2'(m), 1'(d), 3'(g)), 16'h7F06);
        end
    end
    wr(bank(1, 0, 0, 1), 16'h7F00);
    wr(bank(1, 0, 0, 2), 16'h7F02);
    wr(bank(1, 0, 0, 3), 16'h7F01);
    wr(bank(1, 0, 0, 4), 16'h7F04);
    wr(bank(1, 0, 0, 5), 16'h7F05);
    wr(bank(1, 0, 0, 6), 16'h0A06);
    wr(bank(1, 0, 0, 7), 16'h640E);
    wr(bank(1, 3, 0, 0), 16'h7F03);
    wr(bank(1, 3, 0, 1), 16'h7F07);

    // R11 readback
    rd(bank(0, 0, 0, 3), rv); check("R11", rv, 16'h0303, "base readback");
    wr(bank(1, 0, 1, 7), 16'hFFFF);
    rd(bank(1, 0, 1, 7), rv); check("R11", rv, 16'h7F0F, "descriptor write mask");

    split_m = 3'b100;
    wr(8'h82, 16'h0004);
    wr(8'h80, 16'h0201);

    for (int r = 0; r < ROWS; r++) begin
      logic [22:0] e;
      e = TBL[r];
      access(e[22:7], e[6:5], e[4], e[3], e[2]);
      check(row_tag(r), g_ab, e[1], $sformatf("row %0d abort", r));
      check(row_tag(r), g_tr, e[0], $sformatf("row %0d trap", r));
      if (!e[1])
        check(row_tag(r), g_pa, expect_pa(e[22:7], e[6:5], e[4], e[3]),
              $sformatf("row %0d physical address", r));
    end

    // R8 descriptor flags
    rd(bank(1, 0, 0, 0), rv); check("R8", rv, 16'h7F46, "written flag after write");
    rd(bank(1, 0, 0, 4), rv); check("R8", rv, 16'h7FC4, "trapped and written flags");
    rd(bank(1, 0, 0, 2), rv); check("R8", rv, 16'h7F02, "aborted write leaves flag clear");
    wr(bank(1, 0, 0, 4), 16'h7F04);
    rd(bank(1, 0, 0, 4), rv); check("R8", rv, 16'h7F04, "port write clears flags");

    // R9 capture, R10 freeze
    wr(8'h80, 16'h0201);
    access(16'h2345, 2'd0, 1'b1, 1'b0, 1'b1);
    rd(8'h80, rv); check("R9", rv, 16'h8203, "status after nonresident abort");
    rd(8'h81, rv); check("R9", rv, 16'h2345, "fault address");
    access(16'h0010, 2'd3, 1'b1, 1'b0, 1'b0);
    access(16'hC2C0, 2'd0, 1'b1, 1'b0, 1'b0);
    rd(8'h80, rv); check("R10", rv, 16'hC203, "frozen fields, kind bits accumulate");
    rd(8'h81, rv); check("R10", rv, 16'h2345, "fault address frozen");

    wr(8'h80, 16'h0201);
    access(16'hC2C0, 2'd0, 1'b1, 1'b0, 1'b0);
    rd(8'h80, rv); check("R3", rv, 16'h420D, "length abort status");
    rd(8'h81, rv); check("R9", rv, 16'hC2C0, "fault address after length abort");

    wr(8'h80, 16'h0201);
    access(16'h4000, 2'd0, 1'b1, 1'b0, 1'b1);
    rd(8'h80, rv); check("R4", rv, 16'h2205, "read-only abort status");

    // R5 trap enable
    wr(8'h80, 16'h0201);
    access(16'h6000, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R5", g_tr, 1'b1, "trap with enable");
    rd(8'h80, rv); check("R5", rv, 16'h1201, "trap status");
    wr(8'h80, 16'h0001);
    access(16'h6000, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R5", g_tr, 1'b0, "trap suppressed without enable");
    rd(8'h80, rv); check("R5", rv, 16'h1001, "trap status without enable");

    // R6 split off: data reference uses instruction bank
    split_m = 3'b000;
    wr(8'h82, 16'h0000);
    wr(8'h80, 16'h0001);
    access(16'h2000, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R6", g_ab, 1'b1, "split off uses instruction bank");
    access(16'h4100, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R6", g_pa, expect_pa(16'h4100, 2'd1, 1'b0, 1'b0), "supervisor data via instruction bank");

    // R1 disabled again: nothing moves
    wr(8'h80, 16'h0000);
    access(16'h2345, 2'd0, 1'b1, 1'b0, 1'b1);
    check("R1", {g_ab, g_tr}, 2'b00, "flags while off");
    check("R1", g_pa, 22'h002345, "pass-through while off");
    rd(8'h80, rv); check("R1", rv, 16'h0000, "status untouched while off");
    rd(bank(1, 0, 0, 1), rv); check("R1", rv, 16'h7F00, "descriptor untouched while off");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule